// File: doc/BRIEF.md
# Buffered SPI Burst Master

This block is a register-mapped SPI master that moves short bursts of up to nine bytes. Software programs a configuration word that sets the serial clock divider, the clock mode, the bit order, the chip-select polarity, the per-line chip-select enables and an optional shared-wire (half-duplex) mode. It then fills the byte slots and writes a command word. The command names the chip-select line, how many leading bytes carry slot data, how many bytes the burst clocks in total, and whether the chip select should stay active once the burst ends.

While the burst runs, a status bit reads as busy. Each received byte replaces the slot that held the matching outgoing byte. Bytes past the transmit count go out as zero filler, so a read-only burst needs nothing in its slots. Because chip select can be kept active across commands, software can chain bursts into transactions of any length. Writing a configuration word with the enable bit clear stops any burst and releases every chip select.

Top module: `spi_burst_master`

## Requirements
- R1: Register offsets are configuration 0x00, status 0x08 (bit 0 = busy), command 0x10, and byte slot i at 0x80 + 8*i for i = 0..8. Configuration bits are enable [0], chip-select active-high [1], LSB-first [2], shared-wire [3], idle-level select [4], late select [5], chip-select enables [15:12] and clock divider [28:16], and the register reads back what was written in those fields. Out of reset the configuration reads 0, busy is 0, all four chip-select lines are high and the serial clock is low.
- R2: The command word carries the chip-select index in [1:0], the keep-selected flag in [8], the transmit count in [19:16] and the total count in [27:24]. A valid command sets busy from the cycle after the write. Busy stays set for exactly (16*total + 1) * H cycles, where H is the divider field, or 1 when the divider is 0.
- R3: Each serial clock level lasts H system clocks, so the clock period is 2*H.
- R4: When idle, the serial clock rests at (idle-level select XOR late select). With late select 0, data is sampled on the first edge of each bit and the output changes on the second edge. With late select 1, the output changes on the first edge and data is sampled on the second.
- R5: Bytes are sent and received MSB first, or LSB first when bit 2 is set.
- R6: Slots 0 to transmit count - 1 are sent as written, and later bytes go out as 0. After the burst, slots 0 to total - 1 hold the received bytes, and the slots at or above the total count keep their contents.
- R7: During a burst, only the chip-select line named by the command can be active. It becomes active only if its enable bit (12 + index) is set. Active means high when bit 1 is set and low otherwise.
- R8: If the keep-selected flag is 1, the line stays active after the burst. If it is 0, every line is inactive after the burst.
- R9: A command written while busy is ignored. It does not lengthen the running burst and does not start a new one.
- R10: A command is ignored when its total count is 0 or above 9, when its transmit count exceeds its total count, or when the enable bit is clear.
- R11: In shared-wire mode, the data-output enable is 1 only during the transmit-count bytes. Received bits are taken from the shared-line input, so a transmit byte reads back as itself. In normal mode, received bits come from the separate data input.
- R12: Writing the configuration with the enable bit clear ends a running burst at once: busy is 0 in the next cycle and all chip selects are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| spi_sck | output | 1 | Serial clock |
| spi_do | output | 1 | Serial data out |
| spi_do_en | output | 1 | Output enable for spi_do |
| spi_di | input | 1 | Serial data in (normal mode) |
| spi_dio_i | input | 1 | Shared-line input (shared-wire mode) |
| spi_cs | output | 4 | Chip-select lines, at their physical level |

## Verification
The hardest situations to reach from the ports are a command that arrives in the middle of a running burst and a disabling configuration write that lands partway through a burst. The bench polls the status register once per cycle and, at a fixed cycle inside that polling loop, replaces one status read with the extra command or the disabling write. It then checks that the measured busy length and the chip-select levels follow the original burst, or stop at once. The shared-wire echo is reached by a slave model that feeds the shared-line input from the master's own output whenever the output enable is high. Each transmit byte must then read back unchanged while the filler bytes return the slave's data.

// File: rtl/spi_burst_master.sv
module spi_burst_master #(
  parameter int SLOTS = 9,
  parameter int DIV_W = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sck,
  output logic        spi_do,
  output logic        spi_do_en,
  input  logic        spi_di,
  input  logic        spi_dio_i,
  output logic [3:0]  spi_cs
);
  localparam int CNT_W = $clog2(SLOTS * 16 + 1);
  localparam logic [3:0] NSLOT = 4'(SLOTS);
  localparam logic [31:0] CFG_MASK = 32'h0000_F03F | (((32'(1) << DIV_W) - 32'(1)) << 16);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_TAIL} st_t;

  st_t              st;
  logic [31:0]      cfg;
  logic [7:0]       dbuf [SLOTS];
  logic [7:0]       rbuf [SLOTS];
  logic [1:0]       cid;
  logic             keep, cs_on, sck_q;
  logic [3:0]       ntx, ntot;
  logic [DIV_W-1:0] cnt;
  logic [CNT_W-1:0] h, oidx;

  wire en    = cfg[0];
  wire cs_hi = cfg[1];
  wire lsb   = cfg[2];
  wire shw   = cfg[3];
  wire late  = cfg[5];
  wire rest  = cfg[4] ^ cfg[5];
  wire [3:0] cs_ena = cfg[15:12];
  wire [DIV_W-1:0] div  = cfg[16 +: DIV_W];
  wire [DIV_W-1:0] half = (div == '0) ? DIV_W'(1) : div;

  wire busy     = st != S_IDLE;
  wire tick     = busy && cnt == '0;
  wire wr_cfg   = reg_we && reg_addr == 8'h00;
  wire wr_cmd   = reg_we && reg_addr == 8'h10;
  wire [3:0] slot = reg_addr[6:3];
  wire slot_hit = reg_addr[7] && reg_addr[2:0] == 3'd0 && slot < NSLOT;
  wire [3:0] c_tot = reg_wdata[27:24];
  wire [3:0] c_tx  = reg_wdata[19:16];
  wire cmd_ok = wr_cmd && !busy && en && c_tot != 4'd0 && c_tot <= NSLOT && c_tx <= c_tot;

  wire [CNT_W-1:0] nedges = CNT_W'({ntot, 4'b0000});
  wire last_edge = h == nedges - CNT_W'(1);
  wire samp_edge = h[0] == late;

  always_comb oidx = late ? ((h == '0) ? '0 : (h - CNT_W'(1)) >> 1) : h >> 1;

  wire [3:0] obyte = 4'(oidx >> 3);
  wire [2:0] opos  = lsb ? oidx[2:0] : 3'd7 - oidx[2:0];
  wire [3:0] sbyte = 4'(h >> 4);
  wire [2:0] spos  = lsb ? h[3:1] : 3'd7 - h[3:1];
  wire din = shw ? spi_dio_i : spi_di;
  wire [3:0] cs_act = (en && cs_on) ? (cs_ena & (4'b0001 << cid)) : 4'b0000;

  assign spi_sck   = busy ? sck_q : rest;
  assign spi_do    = busy && obyte < ntx && dbuf[obyte][opos];
  assign spi_do_en = en && (!shw || (busy && obyte < ntx));
  assign spi_cs    = cs_hi ? cs_act : ~cs_act;

  always_comb begin
    reg_rdata = 32'd0;
    if (reg_addr == 8'h00)      reg_rdata = cfg;
    else if (reg_addr == 8'h08) reg_rdata = {31'd0, busy};
    else if (slot_hit)          reg_rdata = {24'd0, dbuf[slot]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cfg <= '0; cid <= '0; keep <= 1'b0; cs_on <= 1'b0;
      sck_q <= 1'b0; ntx <= '0; ntot <= '0; cnt <= '0; h <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        dbuf[i] <= '0;
        rbuf[i] <= '0;
      end
    end else begin
      if (reg_we && slot_hit && !busy) dbuf[slot] <= reg_wdata[7:0];
      case (st)
        S_IDLE: if (cmd_ok) begin
          st <= S_SHIFT; cid <= reg_wdata[1:0]; keep <= reg_wdata[8];
          ntx <= c_tx; ntot <= c_tot; cs_on <= 1'b1;
          cnt <= half - DIV_W'(1); h <= '0; sck_q <= rest;
        end
        S_SHIFT: if (tick) begin
          cnt <= half - DIV_W'(1);
          sck_q <= ~sck_q;
          h <= h + CNT_W'(1);
          if (samp_edge) rbuf[sbyte][spos] <= din;
          if (last_edge) st <= S_TAIL;
        end else cnt <= cnt - DIV_W'(1);
        default: if (tick) begin
          st <= S_IDLE;
          cs_on <= keep;
          for (int i = 0; i < SLOTS; i++)
            if (4'(i) < ntot) dbuf[i] <= rbuf[i];
        end else cnt <= cnt - DIV_W'(1);
      endcase
      if (wr_cfg) begin
        cfg <= reg_wdata & CFG_MASK;
        if (!reg_wdata[0]) begin
          st <= S_IDLE;
          cs_on <= 1'b0;
        end
      end
    end
  end

  p_cmd_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ok |=> busy);

  p_rest_after_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT && tick && last_edge) |=> (sck_q == $past(rest)));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TAIL && tick && !keep && !wr_cfg) |=> (spi_cs == {4{~cs_hi}}));

  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_cmd) |=> ($stable(ntot) && $stable(ntx) && $stable(cid)));
endmodule

// File: tb/spi_burst_master_tb_top.sv
module spi_burst_master_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'd0, reg_rdata;
  logic spi_sck, spi_do, spi_do_en, spi_dio_i;
  logic [3:0] spi_cs;
  logic di_q = 1'b0;

  int total = 0, bad = 0;
  int ec = 0;
  bit s_arm = 1'b0;
  bit b_cpha, b_cpol, b_lsb, b_shw, b_cshi;
  logic [3:0] b_ena;
  int b_div;
  logic [7:0] txb [9];
  logic [7:0] sb [9];
  logic [7:0] mark [9];
  logic capb [144];
  logic cape [144];

  always #5 clk = ~clk;

  spi_burst_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_do(spi_do), .spi_do_en(spi_do_en), .spi_di(di_q),
    .spi_dio_i(spi_dio_i), .spi_cs(spi_cs));

  assign spi_dio_i = spi_do_en ? spi_do : di_q;

  function automatic logic slv_bit(int idx);
    int byt = idx / 8;
    int k = idx % 8;
    if (byt > 8) return 1'b0;
    return sb[byt][b_lsb ? k : 7 - k];
  endfunction

  function automatic int out_idx(int e);
    if (b_cpha) return (e == 0) ? 0 : (e - 1) / 2;
    return e / 2;
  endfunction

  function automatic logic [7:0] assemble(int b);
    logic [7:0] v = 8'd0;
    for (int k = 0; k < 8; k++) v[b_lsb ? k : 7 - k] = capb[b * 8 + k];
    return v;
  endfunction

  function automatic logic [3:0] cs_level(bit active, int id);
    logic [3:0] a = (active && b_ena[id]) ? 4'(1 << id) : 4'd0;
    return b_cshi ? a : ~a;
  endfunction

  always @(spi_sck) begin
    if (s_arm) begin
      if ((ec % 2) == int'(b_cpha) && ec < 288) begin
        capb[ec / 2] = spi_do;
        cape[ec / 2] = spi_do_en;
      end
      ec = ec + 1;
      di_q = slv_bit(out_idx(ec));
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic set_cfg(bit cshi, bit lsb, bit shw, bit cpol, bit cpha, logic [3:0] ena, int div);
    logic [31:0] w, r;
    b_cshi = cshi; b_lsb = lsb; b_shw = shw; b_cpol = cpol; b_cpha = cpha;
    b_ena = ena; b_div = (div == 0) ? 1 : div;
    w = 32'd1 | (32'(cshi) << 1) | (32'(lsb) << 2) | (32'(shw) << 3)
      | (32'(cpol ^ cpha) << 4) | (32'(cpha) << 5) | (32'(ena) << 12) | (32'(div) << 16);
    wr(8'h00, w);
    rd(8'h00, r);
    check("R1 cfg readback", r, w);
    check("R4 clock rest level", 32'(spi_sck), 32'(cpol));
  endtask

  task automatic run_xfer(int id, int tx, int tot, bit keep, int act);
    logic [31:0] r, cmd;
    logic [3:0] mid_cs = 4'd0;
    int cyc = 0;
    for (int i = 0; i < 9; i++) begin
      mark[i] = 8'h5A ^ 8'(i * 17);
      wr(8'h80 + 8'(8 * i), 32'(i < tot ? txb[i] : mark[i]));
    end
    cmd = 32'(id) | (32'(keep) << 8) | (32'(tx) << 16) | (32'(tot) << 24);
    ec = 0; di_q = slv_bit(0); s_arm = 1'b1;
    wr(8'h10, cmd);
    forever begin
      if (act == 1 && cyc == 3) begin
        reg_we = 1'b1; reg_addr = 8'h10;
        reg_wdata = 32'((id + 1) % 4) | (32'd1 << 24);
        cyc++;
        @(negedge clk);
        reg_we = 1'b0;
        continue;
      end
      if (act == 2 && cyc == 10) begin
        reg_we = 1'b1; reg_addr = 8'h00; reg_wdata = 32'd0;
        cyc++;
        @(negedge clk);
        reg_we = 1'b0;
        continue;
      end
      rd(8'h08, r);
      if (!r[0]) break;
      if (cyc == 1) mid_cs = spi_cs;
      cyc++;
      @(negedge clk);
    end
    s_arm = 1'b0;
    if (act == 2) begin
      check("R12 abort busy length", 32'(cyc), 32'd11);
      check("R12 abort releases cs", 32'(spi_cs), 32'hF);
      return;
    end
    check("R2 R3 busy cycles", 32'(cyc), 32'((16 * tot + 1) * b_div));
    check("R7 cs during burst", 32'(mid_cs), 32'(cs_level(1'b1, id)));
    check("R8 cs after burst", 32'(spi_cs), 32'(cs_level(keep, id)));
    for (int b = 0; b < tot; b++) begin
      if (!b_shw || b < tx)
        check("R4 R5 R6 sent byte", 32'(assemble(b)), 32'(b < tx ? txb[b] : 8'd0));
      if (b_shw)
        check("R11 output enable", 32'(cape[b * 8]), 32'(b < tx));
    end
    for (int b = 0; b < 9; b++) begin
      rd(8'h80 + 8'(8 * b), r);
      check(b_shw ? "R6 R11 slot readback" : "R6 slot readback", r,
            32'(b >= tot ? mark[b] : ((b_shw && b < tx) ? txb[b] : sb[b])));
    end
    if (act == 1) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        rd(8'h08, r);
        check("R9 no second burst", r, 32'd0);
      end
      check("R9 cs untouched", 32'(spi_cs), 32'(cs_level(keep, id)));
    end
  endtask

  task automatic try_bad(logic [31:0] cmd, string req);
    logic [31:0] r;
    wr(8'h10, cmd);
    rd(8'h08, r);
    check(req, r, 32'd0);
    @(negedge clk);
    rd(8'h08, r);
    check(req, r, 32'd0);
    check(req, 32'(spi_cs), 32'(cs_level(1'b0, 0)));
  endtask

  task automatic rand_bytes();
    for (int i = 0; i < 9; i++) begin
      txb[i] = 8'($urandom);
      sb[i] = 8'($urandom);
    end
  endtask

  initial begin
    logic [31:0] r;
    int seed;
    seed = int'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    rd(8'h00, r); check("R1 reset cfg", r, 32'd0);
    rd(8'h08, r); check("R1 reset busy", r, 32'd0);
    check("R1 reset cs", 32'(spi_cs), 32'hF);
    check("R1 reset sck", 32'(spi_sck), 32'd0);
    try_bad(32'd0 | (32'd3 << 24), "R10 disabled");

    for (int n = 0; n < 24; n++) begin
      int id, tot, tx;
      id = int'($urandom % 4);
      tot = 1 + int'($urandom % 9);
      tx = int'($urandom % (tot + 1));
      rand_bytes();
      set_cfg(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              4'($urandom) | ((n % 3 != 0) ? 4'(1 << id) : 4'd0),
              (n == 2) ? 0 : 1 + int'($urandom % 3));
      run_xfer(id, tx, tot, 1'b0, 0);
    end

    rand_bytes();
    set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF, 2);
    run_xfer(2, 9, 9, 1'b1, 0);
    check("R8 cs held between bursts", 32'(spi_cs), 32'h4 ^ 32'hF);
    rand_bytes();
    run_xfer(2, 0, 9, 1'b0, 0);
    rand_bytes();
    set_cfg(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 1);
    run_xfer(0, 3, 9, 1'b0, 0);

    rand_bytes();
    set_cfg(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 2);
    run_xfer(1, 5, 9, 1'b0, 1);
    rand_bytes();
    run_xfer(3, 4, 4, 1'b1, 1);
    wr(8'h00, 32'd0);
    check("R12 cfg zero releases held cs", 32'(spi_cs), 32'hF);

    set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF, 1);
    try_bad(32'd0, "R10 total zero");
    try_bad(32'd10 << 24, "R10 total above nine");
    try_bad((32'd4 << 24) | (32'd5 << 16), "R10 transmit above total");

    rand_bytes();
    set_cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'hF, 3);
    run_xfer(1, 9, 9, 1'b1, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule